// File: doc/BRIEF.md
# Cache Line Fill Tracker

This block keeps account of a small pool of fill buffers, each of which fetches one cache line as a series of bus-width beats. A buffer is claimed with an address given in beat units. It then asks the memory bus for the beats of its line, one at a time, through a request/grant handshake. Responses come back in request order. A fill may begin at any beat of the line. In that case it wraps round to beat zero after the last beat, which is what happens after a branch into the middle of a line.

For every buffer the block publishes three masks, each with one bit per beat of the line: the beats already requested, the beats already received, and the beats marked as failed. A beat fails either when its response carried an error or when the request for it was blocked by an access-permission check. A pairwise age matrix ranks the buffers. Only the oldest buffer that still owes requests may drive the bus. Each response goes to the oldest buffer that is still waiting for data.

Each buffer runs a four-state machine. FB_IDLE goes to FB_REQ on allocation. FB_REQ goes to FB_WAIT when its last beat is granted or a blocked request ends its requests. FB_REQ goes straight to FB_DONE when a blocked request leaves nothing outstanding. FB_WAIT goes to FB_DONE when the received count catches up with the requested count. Any state returns to FB_IDLE on a flush clear.

A two-state tracker machine sits above the buffers. TOP_RUN goes to TOP_FLUSH on invalidate. TOP_FLUSH goes back to TOP_RUN in the cycle where no requests remain outstanding, and that same transition frees every buffer.

Top module: `fill_line_tracker`

## Requirements
- R1: After reset every buffer is idle. All masks read zero, `bus_req_o` is low and `alloc_ready_o` is high.
- R2: An allocation takes the lowest-numbered idle buffer, and that buffer reads busy from the next cycle. `alloc_ready_o` is low when all buffers are busy or a flush is in progress. An allocation that is not ready is ignored.
- R3: A buffer never requests more beats than a line holds. Once its requested count reaches that number it stops asking, and `bus_req_o` falls if no other buffer is asking.
- R4: `bus_req_o` serves the oldest buffer still owing requests. `bus_addr_o` is that buffer's line base plus (first beat + requested count) mod beats-per-line, times the beat size in bytes. The first beat is the low `log2(beats)` bits of the beat-unit allocation address: bit 0 with the defaults. Mask bit b of buffer i sits at position i*beats+b.
- R5: Responses are taken in order and routed to the oldest buffer whose received count is below its requested count. A buffer's received count never exceeds its requested count. The sum of the differences over busy buffers equals the number of requests outstanding.
- R6: The requested mask and the received mask each have bit (first+k) mod beats set for every k below the respective count, and no other bit.
- R7: While `bus_blocked_i` is high and a buffer is owed a request, `bus_req_o` is low and the grant is not counted. The buffer then stops requesting, and the error bit of the beat it would have fetched next is set.
- R8: A response with `bus_rerr_i` high sets the error bit of beat (first + received count) mod beats of the buffer that takes it.
- R9: After `inval_i` is sampled, no new request or allocation is made until every outstanding response has returned. The cycle after the outstanding count reaches zero, all buffers are idle.
- R10: A grant and a response in the same cycle are both counted, whether they target the same buffer or different buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Request to start a new line fill |
| alloc_addr_i | input | ADDR_W-OFF_W (30) | Fill start address in beat units |
| alloc_ready_o | output | 1 | An allocation would be accepted this cycle |
| inval_i | input | 1 | Drain and free all buffers |
| bus_req_o | output | 1 | Beat request to memory |
| bus_addr_o | output | ADDR_W (32) | Byte address of the requested beat |
| bus_gnt_i | input | 1 | Memory accepts the request |
| bus_blocked_i | input | 1 | Permission check forbids the current request |
| bus_rvalid_i | input | 1 | A response beat arrives |
| bus_rerr_i | input | 1 | The arriving response carries an error |
| fill_busy_o | output | NUM_FB (4) | Buffer is allocated |
| fill_req_mask_o | output | NUM_FB*LINE_BEATS (8) | Beats requested, per buffer |
| fill_rvd_mask_o | output | NUM_FB*LINE_BEATS (8) | Beats received, per buffer |
| fill_err_mask_o | output | NUM_FB*LINE_BEATS (8) | Beats marked failed, per buffer |

## Verification
Two activities can fall in the same cycle. A grant advances one buffer's requested count while a response advances the received count of the same buffer or an older one. The bench forces this with a directed step that grants the second beat of a fill together with the response to its first. The random phase also produces many such overlaps. Each cycle is judged against a bench model that derives masks, bus address and routing from the beat counts alone. A second overlap is an invalidate arriving in the same cycle as a grant. The bench checks that this last grant is still counted, that nothing further is requested, and that buffers are freed only after the final response.

// File: rtl/fill_trk_pkg.sv
package fill_trk_pkg;

    typedef enum logic [1:0] {
        FB_IDLE = 2'd0,
        FB_REQ  = 2'd1,
        FB_WAIT = 2'd2,
        FB_DONE = 2'd3
    } fb_state_e;

    typedef enum logic {
        TOP_RUN   = 1'b0,
        TOP_FLUSH = 1'b1
    } trk_state_e;

endpackage

// File: rtl/fill_beat_mask.sv
module fill_beat_mask #(
    parameter int unsigned LINE_BEATS = 2,
    localparam int unsigned BEAT_IW = $clog2(LINE_BEATS),
    localparam int unsigned CNT_W = BEAT_IW + 1
) (
    input  logic [BEAT_IW-1:0]    first_i,
    input  logic [CNT_W-1:0]      cnt_i,
    output logic [LINE_BEATS-1:0] mask_o
);
    // end index does not wrap: first + count
    logic [CNT_W-1:0] end_beat;
    assign end_beat = {1'b0, first_i} + cnt_i;

    for (genvar b = 0; b < LINE_BEATS; b++) begin : g_bit
        localparam logic [CNT_W-1:0] BIDX  = CNT_W'(b);
        localparam logic [CNT_W-1:0] BWRAP = CNT_W'(b + LINE_BEATS);
        // beats below the first beat are only reached after wrapping
        assign mask_o[b] = (cnt_i != '0) &&
                           (end_beat > ((first_i > BIDX[BEAT_IW-1:0]) ? BWRAP : BIDX));
    end
endmodule

// File: rtl/fill_age_arb.sv
module fill_age_arb #(
    parameter int unsigned NUM_FB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FB-1:0] alloc_oh_i,
    input  logic              clear_i,
    input  logic [NUM_FB-1:0] busy_i,
    input  logic [NUM_FB-1:0] req_cand_i,
    input  logic [NUM_FB-1:0] rsp_cand_i,
    output logic [NUM_FB-1:0] req_sel_o,
    output logic [NUM_FB-1:0] rsp_sel_o
);
    // older_q[i][j] set: buffer j was allocated before buffer i
    logic [NUM_FB-1:0] older_q [NUM_FB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FB; i++) older_q[i] <= '0;
        end else if (clear_i) begin
            for (int i = 0; i < NUM_FB; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_FB; i++) begin
                if (alloc_oh_i[i]) older_q[i] <= busy_i;
            end
        end
    end

    for (genvar i = 0; i < NUM_FB; i++) begin : g_pick
        assign req_sel_o[i] = req_cand_i[i] & ~|(older_q[i] & req_cand_i);
        assign rsp_sel_o[i] = rsp_cand_i[i] & ~|(older_q[i] & rsp_cand_i);

        // R4: age bits only point at buffers that are still allocated
        a_r4_older_busy: assert property (@(posedge clk) disable iff (!rst_n)
            busy_i[i] |-> ((older_q[i] & ~busy_i) == '0));
    end

    // R4: at most one buffer may drive the bus
    a_r4_one_requester: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_sel_o));
    // R5: each response has a single destination
    a_r5_one_receiver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_sel_o));
endmodule

// File: rtl/fill_slot.sv
module fill_slot
    import fill_trk_pkg::*;
#(
    parameter int unsigned LINE_BEATS = 2,
    parameter int unsigned TAG_W = 29,
    localparam int unsigned BEAT_IW = $clog2(LINE_BEATS),
    localparam int unsigned CNT_W = BEAT_IW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic [TAG_W-1:0]      alloc_tag_i,
    input  logic [BEAT_IW-1:0]    alloc_first_i,
    input  logic                  clear_i,
    input  logic                  issue_i,
    input  logic                  block_i,
    input  logic                  rsp_i,
    input  logic                  rsp_err_i,
    output fb_state_e             state_o,
    output logic [CNT_W-1:0]      ext_cnt_o,
    output logic [CNT_W-1:0]      rvd_cnt_o,
    output logic [BEAT_IW-1:0]    first_o,
    output logic [BEAT_IW-1:0]    next_off_o,
    output logic [TAG_W-1:0]      tag_o,
    output logic [LINE_BEATS-1:0] err_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(LINE_BEATS);

    fb_state_e             state_q, state_d;
    logic [CNT_W-1:0]      ext_q, rvd_q, ext_nxt, rvd_nxt;
    logic [BEAT_IW-1:0]    first_q, req_off, rsp_off;
    logic [TAG_W-1:0]      tag_q;
    logic [LINE_BEATS-1:0] err_q, err_d;

    assign ext_nxt = ext_q + CNT_W'(issue_i);
    assign rvd_nxt = rvd_q + CNT_W'(rsp_i);
    // offsets wrap modulo the beats per line by truncation
    assign req_off = first_q + ext_q[BEAT_IW-1:0];
    assign rsp_off = first_q + rvd_q[BEAT_IW-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FB_IDLE: if (alloc_i) state_d = FB_REQ;
            FB_REQ: begin
                if (block_i)              state_d = (rvd_nxt == ext_q) ? FB_DONE : FB_WAIT;
                else if (ext_nxt == FULL) state_d = FB_WAIT;
            end
            FB_WAIT: if (rvd_nxt == ext_q) state_d = FB_DONE;
            FB_DONE: state_d = FB_DONE;
            default: state_d = FB_IDLE;
        endcase
        if (clear_i) state_d = FB_IDLE;
    end

    always_comb begin
        err_d = err_q;
        if (block_i)             err_d[req_off] = 1'b1;
        if (rsp_i && rsp_err_i)  err_d[rsp_off] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FB_IDLE;
            ext_q   <= '0;
            rvd_q   <= '0;
            first_q <= '0;
            tag_q   <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clear_i) begin
                ext_q <= '0;
                rvd_q <= '0;
                err_q <= '0;
            end else if (state_q == FB_IDLE && alloc_i) begin
                ext_q   <= '0;
                rvd_q   <= '0;
                err_q   <= '0;
                first_q <= alloc_first_i;
                tag_q   <= alloc_tag_i;
            end else begin
                ext_q <= ext_nxt;
                rvd_q <= rvd_nxt;
                err_q <= err_d;
            end
        end
    end

    always_comb begin
        state_o    = state_q;
        ext_cnt_o  = ext_q;
        rvd_cnt_o  = rvd_q;
        first_o    = first_q;
        next_off_o = req_off;
        tag_o      = tag_q;
        err_o      = err_q;
    end

    // R3: requested count bounded by the line length
    a_r3_ext_max: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q <= FULL);
    // R3: a full buffer is never in the requesting state
    a_r3_no_req_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FB_REQ) |-> (ext_q < FULL));
    // R5: received never overtakes requested
    a_r5_rvd_le_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rvd_q <= ext_q);
    // R7: a blocked request ends the request phase and counts nothing
    a_r7_block_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (block_i && !clear_i) |=> (state_q != FB_REQ) && (ext_q == $past(ext_q)));
endmodule

// File: rtl/fill_line_tracker.sv
module fill_line_tracker
    import fill_trk_pkg::*;
#(
    parameter int unsigned NUM_FB = 4,
    parameter int unsigned LINE_BEATS = 2,
    parameter int unsigned BUS_W = 32,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned OFF_W = $clog2(BUS_W / 8),
    localparam int unsigned BEAT_IW = $clog2(LINE_BEATS),
    localparam int unsigned CNT_W = BEAT_IW + 1,
    localparam int unsigned TAG_W = ADDR_W - OFF_W - BEAT_IW,
    localparam int unsigned MASK_W = NUM_FB * LINE_BEATS,
    localparam int unsigned PEND_W = $clog2(NUM_FB * LINE_BEATS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid_i,
    input  logic [ADDR_W-OFF_W-1:0] alloc_addr_i,
    output logic                    alloc_ready_o,
    input  logic                    inval_i,
    output logic                    bus_req_o,
    output logic [ADDR_W-1:0]       bus_addr_o,
    input  logic                    bus_gnt_i,
    input  logic                    bus_blocked_i,
    input  logic                    bus_rvalid_i,
    input  logic                    bus_rerr_i,
    output logic [NUM_FB-1:0]       fill_busy_o,
    output logic [MASK_W-1:0]       fill_req_mask_o,
    output logic [MASK_W-1:0]       fill_rvd_mask_o,
    output logic [MASK_W-1:0]       fill_err_mask_o
);
    trk_state_e            trk_q, trk_d;
    fb_state_e             slot_st  [NUM_FB];
    logic [CNT_W-1:0]      ext_cnt  [NUM_FB];
    logic [CNT_W-1:0]      rvd_cnt  [NUM_FB];
    logic [BEAT_IW-1:0]    first_b  [NUM_FB];
    logic [BEAT_IW-1:0]    next_off [NUM_FB];
    logic [TAG_W-1:0]      tag      [NUM_FB];
    logic [LINE_BEATS-1:0] err_b    [NUM_FB];

    logic [NUM_FB-1:0] busy, req_cand, rsp_cand, req_sel, rsp_sel;
    logic [NUM_FB-1:0] alloc_oh, issue, block, rsp;
    logic              run, clear_all, issue_any;
    logic [PEND_W-1:0] pend_q;

    // tracker state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= TOP_RUN;
        else        trk_q <= trk_d;
    end

    always_comb begin
        trk_d = trk_q;
        unique case (trk_q)
            TOP_RUN:   if (inval_i) trk_d = TOP_FLUSH;
            TOP_FLUSH: if (pend_q == '0) trk_d = TOP_RUN;
            default:   trk_d = TOP_RUN;
        endcase
    end

    // control and bus outputs
    always_comb begin
        logic found;
        run       = (trk_q == TOP_RUN);
        clear_all = (trk_q == TOP_FLUSH) && (pend_q == '0);
        alloc_oh  = '0;
        found     = 1'b0;
        for (int i = 0; i < NUM_FB; i++) begin
            if (!busy[i] && !found) begin
                alloc_oh[i] = alloc_valid_i & run;
                found       = 1'b1;
            end
        end
        alloc_ready_o = run & ~&busy;
        bus_req_o     = run & (|req_sel) & ~bus_blocked_i;
        block         = req_sel & {NUM_FB{run & bus_blocked_i}};
        issue         = req_sel & {NUM_FB{bus_req_o & bus_gnt_i}};
        issue_any     = |issue;
        rsp           = rsp_sel & {NUM_FB{bus_rvalid_i}};
        bus_addr_o    = '0;
        for (int i = 0; i < NUM_FB; i++) begin
            if (req_sel[i]) bus_addr_o = bus_addr_o | {tag[i], next_off[i], {OFF_W{1'b0}}};
        end
    end

    // requests outstanding on the bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + PEND_W'(issue_any) - PEND_W'(bus_rvalid_i);
    end

    for (genvar i = 0; i < NUM_FB; i++) begin : g_slot
        fill_slot #(
            .LINE_BEATS (LINE_BEATS),
            .TAG_W      (TAG_W)
        ) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc_i       (alloc_oh[i]),
            .alloc_tag_i   (alloc_addr_i[ADDR_W-OFF_W-1:BEAT_IW]),
            .alloc_first_i (alloc_addr_i[BEAT_IW-1:0]),
            .clear_i       (clear_all),
            .issue_i       (issue[i]),
            .block_i       (block[i]),
            .rsp_i         (rsp[i]),
            .rsp_err_i     (bus_rerr_i),
            .state_o       (slot_st[i]),
            .ext_cnt_o     (ext_cnt[i]),
            .rvd_cnt_o     (rvd_cnt[i]),
            .first_o       (first_b[i]),
            .next_off_o    (next_off[i]),
            .tag_o         (tag[i]),
            .err_o         (err_b[i])
        );

        assign busy[i]     = (slot_st[i] != FB_IDLE);
        assign req_cand[i] = (slot_st[i] == FB_REQ);
        assign rsp_cand[i] = (rvd_cnt[i] < ext_cnt[i]);

        fill_beat_mask #(.LINE_BEATS(LINE_BEATS)) u_req_mask (
            .first_i (first_b[i]),
            .cnt_i   (ext_cnt[i]),
            .mask_o  (fill_req_mask_o[i*LINE_BEATS +: LINE_BEATS])
        );
        fill_beat_mask #(.LINE_BEATS(LINE_BEATS)) u_rvd_mask (
            .first_i (first_b[i]),
            .cnt_i   (rvd_cnt[i]),
            .mask_o  (fill_rvd_mask_o[i*LINE_BEATS +: LINE_BEATS])
        );

        assign fill_err_mask_o[i*LINE_BEATS +: LINE_BEATS] = err_b[i];
        assign fill_busy_o[i] = busy[i];

        // R6: a received beat has always been requested
        a_r6_rvd_within_req: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_rvd_mask_o[i*LINE_BEATS +: LINE_BEATS] &
             ~fill_req_mask_o[i*LINE_BEATS +: LINE_BEATS]) == '0);
    end

    fill_age_arb #(.NUM_FB(NUM_FB)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_oh_i (alloc_oh),
        .clear_i    (clear_all),
        .busy_i     (busy),
        .req_cand_i (req_cand),
        .rsp_cand_i (rsp_cand),
        .req_sel_o  (req_sel),
        .rsp_sel_o  (rsp_sel)
    );

    logic [PEND_W-1:0] gap_sum;
    always_comb begin
        gap_sum = '0;
        for (int i = 0; i < NUM_FB; i++) begin
            if (busy[i]) gap_sum = gap_sum + PEND_W'(ext_cnt[i]) - PEND_W'(rvd_cnt[i]);
        end
    end

    // R5: per-buffer gaps add up to the bus backlog
    a_r5_pend_matches: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q == gap_sum);
    // R9: a drained flush frees every buffer
    a_r9_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q == TOP_FLUSH && pend_q == '0) |=> (fill_busy_o == '0));
    // R9: the backlog cannot grow during a flush
    a_r9_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q == TOP_FLUSH) |=> (pend_q <= $past(pend_q)));
endmodule

// File: tb/fill_line_tracker_tb.sv
module fill_line_tracker_tb;
    localparam int LB = 2;
    localparam int NF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [29:0] alloc_addr = '0;
    logic        inval = 1'b0;
    logic        bus_gnt = 1'b0;
    logic        bus_blocked = 1'b0;
    logic        bus_rvalid = 1'b0;
    logic        bus_rerr = 1'b0;
    logic        alloc_ready, bus_req;
    logic [31:0] bus_addr;
    logic [3:0]  fill_busy;
    logic [7:0]  req_mask, rvd_mask, err_mask;

    always #10 clk = ~clk;

    fill_line_tracker u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .alloc_valid_i   (alloc_valid),
        .alloc_addr_i    (alloc_addr),
        .alloc_ready_o   (alloc_ready),
        .inval_i         (inval),
        .bus_req_o       (bus_req),
        .bus_addr_o      (bus_addr),
        .bus_gnt_i       (bus_gnt),
        .bus_blocked_i   (bus_blocked),
        .bus_rvalid_i    (bus_rvalid),
        .bus_rerr_i      (bus_rerr),
        .fill_busy_o     (fill_busy),
        .fill_req_mask_o (req_mask),
        .fill_rvd_mask_o (rvd_mask),
        .fill_err_mask_o (err_mask)
    );

    int checks = 0;
    int failures = 0;

    // bench model
    bit          m_busy [NF];
    bit          m_pdone[NF];
    int          m_first[NF];
    int          m_ext  [NF];
    int          m_rvd  [NF];
    int          m_seq  [NF];
    bit [1:0]    m_err  [NF];
    logic [28:0] m_tag  [NF];
    bit          m_flush = 1'b0;
    int          seq_ctr = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [1:0] beat_mask(int first, int cnt);
        bit [1:0] m = '0;
        for (int k = 0; k < cnt; k++) m[(first + k) % LB] = 1'b1;
        return m;
    endfunction

    function automatic int oldest_req();
        int r = -1;
        for (int i = 0; i < NF; i++)
            if (m_busy[i] && !m_pdone[i] && m_ext[i] < LB && (r < 0 || m_seq[i] < m_seq[r])) r = i;
        return r;
    endfunction

    function automatic int oldest_rsp();
        int r = -1;
        for (int i = 0; i < NF; i++)
            if (m_busy[i] && m_rvd[i] < m_ext[i] && (r < 0 || m_seq[i] < m_seq[r])) r = i;
        return r;
    endfunction

    function automatic int m_outstanding();
        int s = 0;
        for (int i = 0; i < NF; i++) if (m_busy[i]) s += m_ext[i] - m_rvd[i];
        return s;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NF; i++) begin
            m_busy[i] = 0; m_pdone[i] = 0; m_first[i] = 0; m_ext[i] = 0;
            m_rvd[i] = 0; m_seq[i] = 0; m_err[i] = '0; m_tag[i] = '0;
        end
    endtask

    task automatic step(bit a_v, logic [29:0] a_w, bit gnt, bit blk, bit rv, bit rerr, bit inv);
        int r, t, outn, pick, off;
        bit rdy, clr, exp_req;
        logic [31:0] e_addr;
        @(negedge clk);
        outn = m_outstanding();
        if (outn == 0) rv = 1'b0;
        alloc_valid = a_v; alloc_addr = a_w; bus_gnt = gnt; bus_blocked = blk;
        bus_rvalid = rv; bus_rerr = rerr; inval = inv;
        #1;
        r = oldest_req();
        pick = -1;
        for (int i = 0; i < NF; i++) if (!m_busy[i] && pick < 0) pick = i;
        rdy = !m_flush && pick >= 0;
        chk(m_flush ? "R9 alloc_ready" : "R2 alloc_ready", alloc_ready, rdy);
        exp_req = !m_flush && r >= 0 && !blk;
        chk(blk ? "R7 bus_req" : "R4 bus_req", bus_req, exp_req);
        if (exp_req) begin
            off = (m_first[r] + m_ext[r]) % LB;
            e_addr = {m_tag[r], 1'(off), 2'b00};
            chk("R4 bus_addr", bus_addr, e_addr);
        end
        for (int i = 0; i < NF; i++) begin
            chk("R2 busy", fill_busy[i], m_busy[i]);
            chk("R6 req_mask", req_mask[i*LB +: LB], beat_mask(m_first[i], m_ext[i]));
            chk("R5 rvd_mask", rvd_mask[i*LB +: LB], beat_mask(m_first[i], m_rvd[i]));
            chk(m_pdone[i] ? "R7 err_mask" : "R8 err_mask", err_mask[i*LB +: LB], m_err[i]);
        end
        // advance model
        clr = m_flush && outn == 0;
        t = oldest_rsp();
        if (!m_flush && r >= 0) begin
            off = (m_first[r] + m_ext[r]) % LB;
            if (blk) begin
                m_pdone[r] = 1'b1;
                m_err[r][off] = 1'b1;
            end else if (gnt) begin
                m_ext[r]++;
            end
        end
        if (rv && t >= 0) begin
            if (rerr) m_err[t][(m_first[t] + m_rvd[t]) % LB] = 1'b1;
            m_rvd[t]++;
        end
        if (a_v && rdy) begin
            m_busy[pick] = 1'b1; m_pdone[pick] = 1'b0; m_ext[pick] = 0; m_rvd[pick] = 0;
            m_err[pick] = '0; m_first[pick] = int'(a_w[0]); m_tag[pick] = a_w[29:1];
            m_seq[pick] = seq_ctr; seq_ctr++;
        end
        if (!m_flush && inv) m_flush = 1'b1;
        if (clr) begin
            model_clear();
            m_flush = 1'b0;
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 busy", fill_busy, 4'b0000);
        chk("R1 req_mask", req_mask, 8'h00);
        chk("R1 rvd_mask", rvd_mask, 8'h00);
        chk("R1 err_mask", err_mask, 8'h00);
        chk("R1 bus_req", bus_req, 1'b0);
        chk("R1 alloc_ready", alloc_ready, 1'b1);

        // fill starting at beat 1 of line 0x1000 (byte 0x1004)
        step(1, 30'h401, 0, 0, 0, 0, 0);
        chk("R2 lowest idle", fill_busy, 4'b0001);
        chk("R4 start addr", bus_addr, 32'h1004);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R6 first beat only", req_mask[1:0], 2'b10);
        chk("R4 wrapped addr", bus_addr, 32'h1000);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R6 wrapped mask", req_mask[1:0], 2'b11);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R3 no request when full", bus_req, 1'b0);
        step(0, 0, 0, 0, 1, 1, 0);
        chk("R8 error on beat 1", err_mask[1:0], 2'b10);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R5 all received", rvd_mask[1:0], 2'b11);

        // blocked request on buffer 1, buffer 2 then served
        step(1, 30'h800, 0, 0, 0, 0, 0);
        step(1, 30'hC00, 0, 1, 0, 0, 0);
        chk("R7 blocked err", err_mask[3:2], 2'b01);
        chk("R7 blocked not counted", req_mask[3:2], 2'b00);
        chk("R4 next oldest", bus_addr, 32'h3000);
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0, 0);
        chk("R10 grant counted", req_mask[5:4], 2'b11);
        chk("R10 response counted", rvd_mask[5:4], 2'b01);

        // invalidate with requests in flight
        step(1, 30'h1000, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 1);
        chk("R9 no alloc in flush", alloc_ready, 1'b0);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R9 no request in flush", bus_req, 1'b0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R9 all freed", fill_busy, 4'b0000);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 10) < 3, 30'($urandom), ($urandom % 10) < 6,
                 ($urandom % 20) == 0, ($urandom % 2) == 1,
                 ($urandom % 10) == 0, ($urandom % 50) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule